// File: doc/BRIEF.md
# Raster Timing Generator with Vertical-Blank Interrupt

This block tracks the beam position of a raster display. It counts dots within a scanline and scanlines within a frame. It keeps a vertical-blank status flag and drives an active-high interrupt request toward the processor. Every state change happens on a system clock edge where the pixel clock enable is high. In the intended system that enable fires three times per processor clock, and the processor's work in a cycle is settled before the pixel side moves. The bench also holds the enable high continuously to step through frames quickly.

A frame runs from scanline 0 through scanline 261. Scanline 261 is the pre-render line that closes the frame. Each scanline has 341 dots, numbered 0 to 340. The flag turns on when the counters reach scanline 241, dot 1. It turns off when they reach dot 1 of the pre-render line. A processor read of the status register also clears the flag: the block receives that read as a one-cycle strobe and clears the flag at the next pixel step. The interrupt line is the combinational AND of the flag and the processor's interrupt-enable bit. Setting the enable while the flag is already high therefore gives the processor a fresh rising edge at once.

Top module: `raster_timing`

## Requirements
- R1: On each clock edge with `pix_en` high, `dot` advances by one. From 340 it returns to 0, and `line` then advances by one.
- R2: After scanline 261, dot 340, the next pixel step gives scanline 0, dot 0. Scanline 261 is the last line of the frame.
- R3: On clock edges with `pix_en` low, `line`, `dot` and `vblank` keep their values.
- R4: `vblank` becomes 1 at the pixel step that brings the position to scanline 241, dot 1. Scanline 241, dot 0 still shows 0.
- R5: `vblank` becomes 0 at the pixel step that brings the position to scanline 261, dot 1. Scanline 261, dot 0 still shows 1.
- R6: A one-cycle `stat_rd` pulse clears `vblank` at the first edge with `pix_en` high, at or after the pulse. If `pix_en` is low during the pulse, the request is held until the next pixel step, and `vblank` keeps its value until then.
- R7: If a status read is due at the same pixel step that sets the flag, setting wins and `vblank` reads 1 afterwards.
- R8: `irq` equals `vblank` AND `irq_en` in every cycle, with no register in between.
- R9: Raising `irq_en` while `vblank` is 1 raises `irq` in the same cycle.
- R10: Synchronous active-high `rst` puts the position at scanline 0, dot 0 with `vblank` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel clock enable, one pixel step per high cycle |
| irq_en | input | 1 | Interrupt-enable bit from the control register |
| stat_rd | input | 1 | One-cycle strobe marking a status register read |
| line | output | 9 | Current scanline, 0 to 261 |
| dot | output | 9 | Current dot within the scanline, 0 to 340 |
| vblank | output | 1 | Vertical-blank status flag |
| irq | output | 1 | Active-high interrupt request |

## Verification
`line`, `dot` and `vblank` sit one register away from the pixel step that changes them. Each is due at the first clock edge with `pix_en` high after the stimulus, and not before. `irq` is combinational and is due in the same cycle that `irq_en` or `vblank` changes. The bench drives inputs on the falling edge and counts the exact number of enabled rising edges it applies. It samples on the following falling edge, so each check reads the value after precisely the intended number of steps. For the held status read, the bench samples once before the pixel step and once after it. This shows that the clear waits for the step.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int DOT_W          = 9;
    localparam int LINE_W         = 9;
    localparam int DOTS_PER_LINE  = 341;
    localparam int LINES_PER_FRM  = 262;
    localparam int VBL_LINE       = 241;
    localparam int PRE_LINE       = 261;
    localparam int EDGE_DOT       = 1;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [DOT_W-1:0]  dot;
    } raster_pos_t;

    typedef enum logic [1:0] {
        FLAG_KEEP = 2'd0,
        FLAG_SET  = 2'd1,
        FLAG_CLR  = 2'd2
    } flag_op_e;

    function automatic raster_pos_t pos_step(raster_pos_t p, int dots, int lines);
        raster_pos_t n;
        n = p;
        if (int'(p.dot) == dots - 1) begin
            n.dot = '0;
            if (int'(p.line) == lines - 1) begin
                n.line = '0;
            end else begin
                n.line = p.line + 1'b1;
            end
        end else begin
            n.dot = p.dot + 1'b1;
        end
        return n;
    endfunction

    function automatic logic pos_match(raster_pos_t p, int l, int d);
        return (int'(p.line) == l) && (int'(p.dot) == d);
    endfunction

endpackage

// File: rtl/raster_counter.sv
module raster_counter
    import raster_pkg::*;
#(
    parameter int DOTS  = DOTS_PER_LINE,
    parameter int LINES = LINES_PER_FRM
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pix_en,
    output raster_pos_t pos,
    output raster_pos_t pos_nxt
);

    always_comb begin
        pos_nxt = pos_step(pos, DOTS, LINES);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (pix_en) begin
            pos <= pos_nxt;
        end
    end

endmodule

// File: rtl/vblank_ctrl.sv
module vblank_ctrl
    import raster_pkg::*;
#(
    parameter int SET_LINE = VBL_LINE,
    parameter int CLR_LINE = PRE_LINE,
    parameter int FLAG_DOT = EDGE_DOT
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pix_en,
    input  logic        stat_rd,
    input  raster_pos_t pos_nxt,
    output logic        vblank
);

    logic     rd_pend;
    logic     rd_due;
    flag_op_e op;

    assign rd_due = stat_rd | rd_pend;

    // Setting has priority over any clear landing on the same pixel step.
    always_comb begin
        op = FLAG_KEEP;
        if (pix_en) begin
            if (pos_match(pos_nxt, SET_LINE, FLAG_DOT)) begin
                op = FLAG_SET;
            end else if (pos_match(pos_nxt, CLR_LINE, FLAG_DOT) || rd_due) begin
                op = FLAG_CLR;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend <= 1'b0;
        end else if (pix_en) begin
            rd_pend <= 1'b0;
        end else if (stat_rd) begin
            rd_pend <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vblank <= 1'b0;
        end else begin
            case (op)
                FLAG_SET: vblank <= 1'b1;
                FLAG_CLR: vblank <= 1'b0;
                default:  vblank <= vblank;
            endcase
        end
    end

endmodule

// File: rtl/irq_gate.sv
module irq_gate (
    input  logic vblank,
    input  logic irq_en,
    output logic irq
);

    assign irq = vblank & irq_en;

endmodule

// File: rtl/raster_timing.sv
module raster_timing
    import raster_pkg::*;
#(
    parameter int DOTS     = DOTS_PER_LINE,
    parameter int LINES    = LINES_PER_FRM,
    parameter int SET_LINE = VBL_LINE,
    parameter int CLR_LINE = PRE_LINE,
    parameter int FLAG_DOT = EDGE_DOT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_en,
    input  logic              irq_en,
    input  logic              stat_rd,
    output logic [LINE_W-1:0] line,
    output logic [DOT_W-1:0]  dot,
    output logic              vblank,
    output logic              irq
);

    raster_pos_t pos;
    raster_pos_t pos_nxt;

    raster_counter #(
        .DOTS  (DOTS),
        .LINES (LINES)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .pix_en  (pix_en),
        .pos     (pos),
        .pos_nxt (pos_nxt)
    );

    vblank_ctrl #(
        .SET_LINE (SET_LINE),
        .CLR_LINE (CLR_LINE),
        .FLAG_DOT (FLAG_DOT)
    ) u_vbl (
        .clk     (clk),
        .rst     (rst),
        .pix_en  (pix_en),
        .stat_rd (stat_rd),
        .pos_nxt (pos_nxt),
        .vblank  (vblank)
    );

    irq_gate u_irq (
        .vblank (vblank),
        .irq_en (irq_en),
        .irq    (irq)
    );

    assign line = pos.line;
    assign dot  = pos.dot;

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
    import raster_pkg::*;
#(
    parameter int DOTS     = DOTS_PER_LINE,
    parameter int LINES    = LINES_PER_FRM,
    parameter int SET_LINE = VBL_LINE,
    parameter int CLR_LINE = PRE_LINE,
    parameter int FLAG_DOT = EDGE_DOT
) (
    input logic              clk,
    input logic              rst,
    input logic              pix_en,
    input logic              irq_en,
    input logic              stat_rd,
    input logic [LINE_W-1:0] line,
    input logic [DOT_W-1:0]  dot,
    input logic              vblank,
    input logic              irq
);

    localparam logic [DOT_W-1:0]  LAST_DOT  = DOT_W'(DOTS - 1);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);
    localparam logic [DOT_W-1:0]  PRE_DOT   = DOT_W'(FLAG_DOT - 1);
    localparam logic [LINE_W-1:0] SET_L     = LINE_W'(SET_LINE);
    localparam logic [LINE_W-1:0] CLR_L     = LINE_W'(CLR_LINE);

    AST_DOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (pix_en && dot != LAST_DOT) |=> (dot == $past(dot) + 1'b1) && $stable(line)) // R1
        else $error("dot step");
    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (pix_en && dot == LAST_DOT && line == LAST_LINE) |=> (line == '0 && dot == '0)) // R2
        else $error("frame wrap");
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(line) && $stable(dot) && $stable(vblank))) // R3
        else $error("hold without enable");
    AST_VBL_SET: assert property (@(posedge clk) disable iff (rst)
        (pix_en && line == SET_L && dot == PRE_DOT) |=> vblank) // R4
        else $error("flag set");
    AST_VBL_CLR: assert property (@(posedge clk) disable iff (rst)
        (pix_en && line == CLR_L && dot == PRE_DOT) |=> !vblank) // R5
        else $error("flag clear");
    AST_RD_CLR: assert property (@(posedge clk) disable iff (rst)
        (pix_en && stat_rd && !(line == SET_L && dot == PRE_DOT)) |=> !vblank) // R6
        else $error("read clear");
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_en) && vblank) |-> irq) // R9
        else $error("enable rise");
    AST_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (line == '0 && dot == '0 && !vblank)) // R10
        else $error("reset state");

endmodule

bind raster_timing raster_timing_chk #(
    .DOTS     (DOTS),
    .LINES    (LINES),
    .SET_LINE (SET_LINE),
    .CLR_LINE (CLR_LINE),
    .FLAG_DOT (FLAG_DOT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pix_en  (pix_en),
    .irq_en  (irq_en),
    .stat_rd (stat_rd),
    .line    (line),
    .dot     (dot),
    .vblank  (vblank),
    .irq     (irq)
);

// File: tb/raster_timing_tb.sv
module raster_timing_tb;

    localparam int NDOT   = 341;
    localparam int NLINE  = 262;
    localparam int FRAME  = NDOT * NLINE;
    localparam int NVEC   = 14;
    localparam int WD_CYC = 190000;

    // Each row: line, dot, irq_en, expected vblank, expected irq
    localparam int VEC [NVEC][5] = '{
        '{  0,   5, 0, 0, 0},
        '{  0, 340, 1, 0, 0},
        '{  1,   0, 0, 0, 0},
        '{240, 340, 0, 0, 0},
        '{241,   0, 1, 0, 0},
        '{241,   1, 0, 1, 0},
        '{241,   1, 1, 1, 1},
        '{241,   2, 1, 1, 1},
        '{260, 340, 0, 1, 0},
        '{261,   0, 1, 1, 1},
        '{261,   1, 1, 0, 0},
        '{261, 340, 0, 0, 0},
        '{  0,   0, 0, 0, 0},
        '{  0,   1, 0, 0, 0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_en = 1'b0;
    logic       irq_en = 1'b0;
    logic       stat_rd = 1'b0;
    logic [8:0] line;
    logic [8:0] dot;
    logic       vblank;
    logic       irq;

    int total = 0;
    int bad = 0;
    int cur = 0;

    always #5 clk = ~clk;

    raster_timing u_dut (
        .clk     (clk),
        .rst     (rst),
        .pix_en  (pix_en),
        .irq_en  (irq_en),
        .stat_rd (stat_rd),
        .line    (line),
        .dot     (dot),
        .vblank  (vblank),
        .irq     (irq)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_pos(input string req, input int l, input int d);
        check(req, "line", int'(line), l);
        check(req, "dot", int'(dot), d);
    endtask

    // Called on a falling edge; leaves on a falling edge with pix_en low.
    task automatic go_to(input int l, input int d);
        int tgt;
        int delta;
        tgt   = l * NDOT + d;
        delta = (tgt - cur + FRAME) % FRAME;
        if (delta > 0) begin
            pix_en = 1'b1;
            repeat (delta) @(posedge clk);
            @(negedge clk);
            pix_en = 1'b0;
        end
        cur = tgt;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check_pos("R10", 0, 0);
        check("R10", "vblank", int'(vblank), 0);

        // R3: no enable, nothing moves
        repeat (4) @(negedge clk);
        check_pos("R3", 0, 0);

        // Table walk through one full frame and the wrap (R1 R2 R4 R5 R8 R9)
        for (int i = 0; i < NVEC; i++) begin
            irq_en = VEC[i][2][0];
            go_to(VEC[i][0], VEC[i][1]);
            #1;
            check_pos("R1/R2", VEC[i][0], VEC[i][1]);
            check("R4/R5", "vblank", int'(vblank), VEC[i][3]);
            check("R8/R9", "irq", int'(irq), VEC[i][4]);
            @(negedge clk);
        end
        irq_en = 1'b0;

        // R7: read strobe on the same step that sets the flag
        go_to(241, 0);
        check("R4", "vblank before set", int'(vblank), 0);
        stat_rd = 1'b1;
        pix_en  = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        pix_en  = 1'b0;
        cur     = 241 * NDOT + 1;
        check_pos("R7", 241, 1);
        check("R7", "vblank", int'(vblank), 1);
        go_to(241, 2);
        check("R7", "vblank one step later", int'(vblank), 1);

        // R6: read with pix_en low is held until the next pixel step
        go_to(241, 3);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        @(negedge clk);
        check("R6", "vblank before step", int'(vblank), 1);
        check_pos("R6", 241, 3);
        go_to(241, 4);
        check("R6", "vblank after step", int'(vblank), 0);
        irq_en = 1'b1;
        #1;
        check("R8", "irq with flag clear", int'(irq), 0);

        // R10: reset from mid-frame
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_pos("R10", 0, 0);
        check("R10", "vblank after reset", int'(vblank), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule